// File: doc/BRIEF.md
# Rotary dial pulse decoder

This block turns the clean digital image of a rotary-dial loop line into dialled digits. Each rising edge on the line adds one to the pulse tally of the digit in progress. Every counted edge restarts a gap timer. The timer runs on a tick taken from the system clock through a prescaler. When the timer reaches its limit with no further edge, the digit is closed. Its tally is mapped to a digit value, which is written into the next free slot of a small buffer.

The output side has no back-pressure. A completed digit appears once, for one cycle, on the `digit_valid` strobe together with `digit_value`. The buffer keeps every stored digit, so a consumer that misses the strobe can still read the slot later through `digit_buf`. `digit_count` tells how many slots are filled. When the buffer is full, further digits are thrown away and a sticky `overflow` flag is raised. A one-cycle `clr` empties the buffer and lowers the flag.

Top module: `rotary_dial_decoder`

## Requirements
- R1: After reset `digit_count` is 0, `overflow` is 0, `digit_valid` is 0 and every 4-bit slot of `digit_buf` is 0.
- R2: A train of n rising edges (1 to 9) with no gap reaching the timeout closes as one digit whose value is n.
- R3: A train of exactly ten edges is stored as value 0. A train of eleven or more edges is stored as 4'hF.
- R4: The timer restarts on every rising edge. A digit closes GAP_TICKS prescaler ticks after its last edge, with one tick of uncertainty, and never while edges keep arriving closer together than that. A tick occurs once every CLK_DIV clock cycles. `digit_valid` rises between (GAP_TICKS-1)*CLK_DIV+2 and GAP_TICKS*CLK_DIV+2 cycles after the clock edge that samples the final rise.
- R5: Each stored digit gives a single-cycle `digit_valid` pulse carrying its value. The digit is written to slot k = the old `digit_count`, held in `digit_buf[4k+3:4k]`, and `digit_count` then goes up by one.
- R6: Once the timer has fired it stays disarmed, so a line with no further edges produces no more digits.
- R7: When `digit_count` equals MAX_DIGITS, a completed digit is dropped. It gives no strobe, leaves the count and the buffer unchanged, and sets `overflow`, which stays set until `clr` or reset.
- R8: `clr` high for a cycle sets `digit_count` to 0, clears `overflow` and zeroes all slots. The next digit goes into slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Conditioned loop line; rising edges are pulses |
| clr | input | 1 | Synchronous buffer clear |
| digit_valid | output | 1 | One-cycle strobe for a newly stored digit |
| digit_value | output | 4 | Value of the digit on the strobe |
| digit_buf | output | MAX_DIGITS*4 | Stored digits, slot k at bits 4k+3:4k |
| digit_count | output | $clog2(MAX_DIGITS+1) | Number of filled slots |
| overflow | output | 1 | Sticky flag: a digit was dropped because the buffer was full |

## Verification
The assertions check on every cycle the properties that hold at any instant. They cover the tick spacing, that an edge arms the timer and that the tally is zero while the timer is idle, that each strobe comes with a count step of exactly one, the count bound, the stickiness of the overflow flag, and the effect of a clear. The bench scenarios are what show the edge-to-value mapping, including ten pulses and runaway tallies. They also show that spaced trains stay whole, the timing window from the last edge to the strobe, silence on an idle line, slot contents, dropping at full and refilling after a clear.

// File: rtl/rdd_pkg.sv
package rdd_pkg;
  localparam int DIGIT_W = 4;
  localparam int TALLY_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [TALLY_W-1:0] tally_t;

  // tally 10 -> 0, 1..9 -> itself, above 10 -> error code F
  function automatic digit_t tally_to_digit(input tally_t t);
    if (t == tally_t'(10)) return digit_t'(0);
    else if (t > tally_t'(10)) return digit_t'(4'hF);
    else return digit_t'(t);
  endfunction
endpackage

// File: rtl/rdd_tick_gen.sv
module rdd_tick_gen #(
  parameter int CLK_DIV = 128
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(CLK_DIV);
      logic [DW-1:0] div_cnt;
      always_ff @(posedge clk) begin
        if (rst) div_cnt <= '0;
        else if (div_cnt == DW'(CLK_DIV - 1)) div_cnt <= '0;
        else div_cnt <= div_cnt + 1'b1;
      end
      assign tick = (div_cnt == DW'(CLK_DIV - 1));

      assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rdd_pulse_timer.sv
module rdd_pulse_timer
  import rdd_pkg::*;
#(
  parameter int GAP_TICKS = 3125
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   line_in,
  input  logic   tick,
  output logic   done,
  output digit_t done_digit
);
  localparam int TW = $clog2(GAP_TICKS + 1);

  logic          line_q;
  logic          rise;
  logic          armed;
  logic [TW-1:0] gap_cnt;
  tally_t        tally;
  logic          expire;

  assign rise   = line_in & ~line_q;
  assign expire = armed & tick & (gap_cnt == TW'(GAP_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q     <= 1'b0;
      armed      <= 1'b0;
      gap_cnt    <= '0;
      tally      <= '0;
      done       <= 1'b0;
      done_digit <= '0;
    end else begin
      line_q <= line_in;
      done   <= 1'b0;
      if (rise) begin
        armed   <= 1'b1;
        gap_cnt <= '0;
        if (tally != '1) tally <= tally + 1'b1;
      end else if (expire) begin
        armed      <= 1'b0;
        gap_cnt    <= '0;
        tally      <= '0;
        done       <= 1'b1;
        done_digit <= tally_to_digit(tally);
      end else if (armed && tick) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  assert_rise_arms_R2: assert property (@(posedge clk) disable iff (rst)
    rise |=> (armed && tally != '0));
  assert_idle_empty_R6: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (tally == '0 && gap_cnt == '0));
  assert_done_from_armed_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!armed && $past(armed)));
endmodule

// File: rtl/rdd_digit_store.sv
module rdd_digit_store
  import rdd_pkg::*;
#(
  parameter int MAX_DIGITS = 20,
  localparam int CW = $clog2(MAX_DIGITS + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          done,
  input  digit_t                        done_digit,
  output logic                          digit_valid,
  output digit_t                        digit_value,
  output logic [MAX_DIGITS*DIGIT_W-1:0] digit_buf,
  output logic [CW-1:0]                 digit_count,
  output logic                          overflow
);
  digit_t slots [MAX_DIGITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      digit_count <= '0;
      overflow    <= 1'b0;
      digit_valid <= 1'b0;
      digit_value <= '0;
      for (int i = 0; i < MAX_DIGITS; i++) slots[i] <= '0;
    end else if (clr) begin
      digit_count <= '0;
      overflow    <= 1'b0;
      digit_valid <= 1'b0;
      for (int i = 0; i < MAX_DIGITS; i++) slots[i] <= '0;
    end else begin
      digit_valid <= 1'b0;
      if (done) begin
        if (digit_count < CW'(MAX_DIGITS)) begin
          for (int i = 0; i < MAX_DIGITS; i++)
            if (digit_count == CW'(i)) slots[i] <= done_digit;
          digit_count <= digit_count + 1'b1;
          digit_valid <= 1'b1;
          digit_value <= done_digit;
        end else begin
          overflow <= 1'b1;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < MAX_DIGITS; g++) begin : g_flat
      assign digit_buf[g*DIGIT_W +: DIGIT_W] = slots[g];
    end
  endgenerate

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    digit_count <= CW'(MAX_DIGITS));
  assert_valid_steps_R5: assert property (@(posedge clk) disable iff (rst)
    digit_valid |-> (digit_count == CW'($past(digit_count) + 1'b1)));
  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(overflow) && !$past(clr)) |-> overflow);
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (digit_count == '0 && !overflow && !digit_valid));
endmodule

// File: rtl/rotary_dial_decoder.sv
module rotary_dial_decoder
  import rdd_pkg::*;
#(
  parameter int CLK_DIV    = 128,
  parameter int GAP_TICKS  = 3125,
  parameter int MAX_DIGITS = 20,
  localparam int CW = $clog2(MAX_DIGITS + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          line_in,
  input  logic                          clr,
  output logic                          digit_valid,
  output logic [DIGIT_W-1:0]            digit_value,
  output logic [MAX_DIGITS*DIGIT_W-1:0] digit_buf,
  output logic [CW-1:0]                 digit_count,
  output logic                          overflow
);
  logic   tick;
  logic   done;
  digit_t done_digit;

  rdd_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  rdd_pulse_timer #(.GAP_TICKS(GAP_TICKS)) u_timer (
    .clk(clk), .rst(rst), .line_in(line_in), .tick(tick),
    .done(done), .done_digit(done_digit)
  );

  rdd_digit_store #(.MAX_DIGITS(MAX_DIGITS)) u_store (
    .clk(clk), .rst(rst), .clr(clr), .done(done), .done_digit(done_digit),
    .digit_valid(digit_valid), .digit_value(digit_value),
    .digit_buf(digit_buf), .digit_count(digit_count), .overflow(overflow)
  );
endmodule

// File: tb/rotary_dial_decoder_bench.sv
module rotary_dial_decoder_bench;
  localparam int DIV  = 4;
  localparam int GAP  = 25;
  localparam int MAXD = 8;
  localparam int CW   = $clog2(MAXD + 1);

  logic clk = 0, rst = 1, line_in = 0, clr = 0;
  logic digit_valid, overflow;
  logic [3:0] digit_value;
  logic [MAXD*4-1:0] digit_buf;
  logic [CW-1:0] digit_count;

  rotary_dial_decoder #(.CLK_DIV(DIV), .GAP_TICKS(GAP), .MAX_DIGITS(MAXD)) u_rotary_dial_decoder (
    .clk(clk), .rst(rst), .line_in(line_in), .clr(clr),
    .digit_valid(digit_valid), .digit_value(digit_value),
    .digit_buf(digit_buf), .digit_count(digit_count), .overflow(overflow)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  int vcnt = 0, vtime = 0, last_rise = 0;
  logic [3:0] vdig = 0;
  int m_count = 0;
  bit m_ovf = 0;
  logic [3:0] m_buf [MAXD];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!rst && digit_valid) begin
    vcnt  <= vcnt + 1;
    vdig  <= digit_value;
    vtime <= cyc;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_digit(input int n);
    if (n == 10) return 4'd0;
    if (n > 10) return 4'hF;
    return 4'(n);
  endfunction

  task automatic dial(input int n, input string req);
    int v0;
    v0 = vcnt;
    for (int p = 0; p < n; p++) begin
      @(negedge clk); line_in = 1; last_rise = cyc;
      repeat ($urandom_range(8, 30)) @(negedge clk);
      line_in = 0;
      repeat ($urandom_range(8, 30)) @(negedge clk);
    end
    check(vcnt == v0, {req, " R4 no split during train"}, vcnt - v0, 0);
    repeat (GAP * DIV + 20) @(negedge clk);
    if (m_count < MAXD) begin
      m_buf[m_count] = exp_digit(n);
      check(vcnt == v0 + 1, {req, " R5 one strobe"}, vcnt - v0, 1);
      check(vdig == exp_digit(n), {req, " digit value"}, vdig, exp_digit(n));
      check(vtime - last_rise >= (GAP-1)*DIV && vtime - last_rise <= GAP*DIV + 4,
            {req, " R4 latency window"}, vtime - last_rise, GAP*DIV);
      check(digit_buf[m_count*4 +: 4] == m_buf[m_count], {req, " R5 slot"},
            digit_buf[m_count*4 +: 4], m_buf[m_count]);
      m_count++;
    end else begin
      m_ovf = 1;
      check(vcnt == v0, {req, " R7 dropped no strobe"}, vcnt - v0, 0);
    end
    check(digit_count == CW'(m_count), {req, " count"}, digit_count, m_count);
    check(overflow == m_ovf, {req, " R7 overflow flag"}, overflow, m_ovf);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(digit_count == 0, "R1 count", digit_count, 0);
    check(overflow == 0, "R1 overflow", overflow, 0);
    check(digit_valid == 0, "R1 valid", digit_valid, 0);
    check(digit_buf == '0, "R1 buffer", 0, 0);

    dial(1, "R2 one pulse");
    dial(10, "R3 ten pulses");
    dial(12, "R3 twelve pulses");
    v0 = vcnt;
    repeat (600) @(negedge clk);
    check(vcnt == v0, "R6 idle line quiet", vcnt - v0, 0);
    for (int k = 0; k < 5; k++) dial($urandom_range(1, 9), "R2 random digit");
    dial(4, "R7 full drop");
    dial(7, "R7 still dropping");
    for (int s = 0; s < MAXD; s++)
      check(digit_buf[s*4 +: 4] == m_buf[s], "R7 buffer unchanged", digit_buf[s*4 +: 4], m_buf[s]);

    clr = 1; @(negedge clk); clr = 0;
    m_count = 0; m_ovf = 0;
    check(digit_count == 0, "R8 count cleared", digit_count, 0);
    check(overflow == 0, "R8 overflow cleared", overflow, 0);
    check(digit_buf == '0, "R8 buffer cleared", 0, 0);
    dial(3, "R8 refill slot 0");
    for (int k = 0; k < 3; k++) dial($urandom_range(1, 10), "R2 random after clear");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule